// File: doc/BRIEF.md
# One-Time-Programmable Sum-of-Products Logic Array

This block is a field-configurable logic array. Sixteen inputs feed 48 shared product terms. Any of the product terms can be summed onto any of 8 outputs. Each output then passes through a polarity stage that can be set to invert it, and through a gate controlled by an active-low chip enable. The path from the data inputs to the outputs is purely combinational. The only clocked logic is the configuration store.

Every configuration element is a register that models a fuse. An element starts out intact (1) and can only be blown (0). Each product term has two links per input: a true link and a complement link. When a link is blown it drops out of the AND. When both links of a pair stay intact, the term is forced off. Each product term also has one OR link per output, and each output has one polarity link.

A synchronous reset returns every element to the intact (virgin) state, as on a fresh part. Configuration uses one address for both writes and readback:
- `cfg_sel` picks the element kind: 0 = AND true link, 1 = AND complement link, 2 = OR link, 3 = polarity.
- `cfg_term` picks the product term.
- `cfg_idx` picks the input for AND links, or the output for OR and polarity links.

The parameter `OPEN_DRAIN` selects how the output pins behave when disabled: tri-state (0) or open-collector (1).

Top module: `pla_array`

## Requirements
- R1: After reset every link reads back 1 (intact). With `ce_n` low, every output result is 0, because every product term is inhibited and no output is inverted.
- R2: Each term input follows its link pair as follows:
  - only the true link intact: the term needs the input high.
  - only the complement link intact: the term needs the input low.
  - both links blown: the input does not matter.
  - both links intact: the term is 0.
- R3: The OR sum of an output includes a product term exactly when that term's OR link for the output is intact.
- R4: An output whose polarity link is blown presents the inverted OR sum. An intact polarity link passes the sum unchanged.
- R5: A write with `cfg_blow`=1 blows the addressed link. A write with `cfg_blow`=0 to a blown link leaves it blown and raises `cfg_err` in the cycle after the write. A write with `cfg_blow`=0 to an intact link changes nothing and raises no error.
- R6: A write is ignored and raises `cfg_err` in the next cycle if its address is out of range. The address is out of range when `cfg_term` ≥ 48, when `cfg_idx` ≥ 16 for an AND link, or when `cfg_idx` ≥ 8 for an OR or polarity link.
- R7: `cfg_rdata` returns the state of the addressed link combinationally: 1 if intact, 0 if blown. It returns 0 for an out-of-range address.
- R8: With `ce_n` high, `out_en` is all zeros.
- R9: In tri-state mode with `ce_n` low, `out_en` is all ones and `out_val` is the result. With `ce_n` high, `out_val` is 0.
- R10: In open-collector mode with `ce_n` low, `out_en[i]` is high exactly when result bit i is 0, and `out_val` equals the result. With `ce_n` high, `out_val` is all ones (released high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset to the virgin state, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Element kind: 0 AND true, 1 AND complement, 2 OR, 3 polarity |
| cfg_term | input | 6 | Product term index |
| cfg_idx | input | 4 | Input index (AND) or output index (OR, polarity) |
| cfg_blow | input | 1 | 1 blows the link, 0 requests an intact link |
| cfg_rdata | output | 1 | Readback of the addressed link, 1 = intact |
| cfg_err | output | 1 | Registered flag for a restore attempt or a bad address |
| ce_n | input | 1 | Chip enable, active low |
| data_in | input | 16 | Logic inputs |
| out_val | output | 8 | Level seen on each output |
| out_en | output | 8 | Per-output drive enable |

## Verification
The bench checks the four states of a link pair, including a pair left fully intact inside an otherwise don't-care term. A design that decodes the pair as a single literal would fire that term on most input vectors.

It also attempts to restore a blown link. A design without one-time semantics would read the link back as intact and re-enable the term, and it would not raise the error flag. Out-of-range terms and output indices are written as well. Here a design that wraps the address would corrupt a valid link, and this shows up in the full readback sweep.

Both output modes run side by side. A swapped drive sense in open-collector mode, or a tri-state output that stays enabled when chip enable is high, shows up on every vector.

// File: rtl/pla_pkg.sv
`timescale 1ns/1ps
package pla_pkg;
   // kind of configuration element addressed by the port
   typedef enum logic [1:0] {
      SEL_AND_T = 2'd0,
      SEL_AND_C = 2'd1,
      SEL_OR    = 2'd2,
      SEL_POL   = 2'd3
   } pla_sel_e;
endpackage

// File: rtl/pla_fuse_bank.sv
`timescale 1ns/1ps
module pla_fuse_bank
   import pla_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8,
   parameter int TW     = 6,
   parameter int IW     = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cfg_we,
   input  pla_sel_e                cfg_sel,
   input  logic [TW-1:0]           cfg_term,
   input  logic [IW-1:0]           cfg_idx,
   input  logic                    cfg_blow,
   output logic [N_TERM*N_IN-1:0]  and_t_ok,
   output logic [N_TERM*N_IN-1:0]  and_c_ok,
   output logic [N_TERM*N_OUT-1:0] or_ok,
   output logic [N_OUT-1:0]        pol_ok,
   output logic                    rd_intact,
   output logic                    cfg_err
);
   localparam int AW = $clog2(N_TERM*N_IN);
   localparam int OW = $clog2(N_TERM*N_OUT);
   localparam int PW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

   logic          addr_ok;
   logic [AW-1:0] a_pos;
   logic [OW-1:0] o_pos;
   logic [PW-1:0] p_pos;
   logic          cur;

   assign a_pos = AW'(cfg_term) * AW'(N_IN) + AW'(cfg_idx);
   assign o_pos = OW'(cfg_term) * OW'(N_OUT) + OW'(cfg_idx);
   assign p_pos = PW'(cfg_idx);

   always_comb begin
      addr_ok = (int'(cfg_term) < N_TERM);
      if (cfg_sel == SEL_AND_T || cfg_sel == SEL_AND_C)
         addr_ok = addr_ok && (int'(cfg_idx) < N_IN);
      else
         addr_ok = addr_ok && (int'(cfg_idx) < N_OUT);
   end

   always_comb begin
      cur = 1'b0;
      if (addr_ok) begin
         unique case (cfg_sel)
            SEL_AND_T: cur = and_t_ok[a_pos];
            SEL_AND_C: cur = and_c_ok[a_pos];
            SEL_OR:    cur = or_ok[o_pos];
            SEL_POL:   cur = pol_ok[p_pos];
            default:   cur = 1'b0;
         endcase
      end
   end

   assign rd_intact = cur;

   always_ff @(posedge clk) begin
      if (rst) begin
         and_t_ok <= '1;
         and_c_ok <= '1;
         or_ok    <= '1;
         pol_ok   <= '1;
         cfg_err  <= 1'b0;
      end else begin
         cfg_err <= 1'b0;
         if (cfg_we) begin
            if (!addr_ok || (!cfg_blow && !cur)) begin
               cfg_err <= 1'b1;
            end else if (cfg_blow) begin
               unique case (cfg_sel)
                  SEL_AND_T: and_t_ok[a_pos] <= 1'b0;
                  SEL_AND_C: and_c_ok[a_pos] <= 1'b0;
                  SEL_OR:    or_ok[o_pos]    <= 1'b0;
                  SEL_POL:   pol_ok[p_pos]   <= 1'b0;
                  default:   ;
               endcase
            end
         end
      end
   end

   // R5
   otp_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> ((~$past({and_t_ok, and_c_ok, or_ok, pol_ok}) &
                        {and_t_ok, and_c_ok, or_ok, pol_ok}) == '0));

   // R5
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cfg_we)) |-> $stable({and_t_ok, and_c_ok, or_ok, pol_ok}));

   // R6
   err_cause_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> ($past(cfg_we) && !$past(rst)));
endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane #(
   parameter int N_IN   = 16,
   parameter int N_TERM = 48
) (
   input  logic [N_IN-1:0]         data_in,
   input  logic [N_TERM*N_IN-1:0]  and_t_ok,
   input  logic [N_TERM*N_IN-1:0]  and_c_ok,
   output logic [N_TERM-1:0]       term_hit
);
   for (genvar p = 0; p < N_TERM; p++) begin : g_term
      logic [N_IN-1:0] t_row, c_row, lit;
      assign t_row = and_t_ok[p*N_IN +: N_IN];
      assign c_row = and_c_ok[p*N_IN +: N_IN];
      // an intact true link demands a 1, an intact complement link a 0
      assign lit = (~t_row | data_in) & (~c_row | ~data_in);
      assign term_hit[p] = &lit;
   end
endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
   parameter int N_TERM = 48,
   parameter int N_OUT  = 8
) (
   input  logic [N_TERM-1:0]       term_hit,
   input  logic [N_TERM*N_OUT-1:0] or_ok,
   input  logic [N_OUT-1:0]        pol_ok,
   output logic [N_OUT-1:0]        result
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_TERM-1:0] col;
      logic              sum;
      for (genvar p = 0; p < N_TERM; p++) begin : g_col
         assign col[p] = or_ok[p*N_OUT + o];
      end
      assign sum = |(term_hit & col);
      // a blown polarity link turns the stage into an inverter
      assign result[o] = sum ^ ~pol_ok[o];
   end
endmodule

// File: rtl/pla_array.sv
`timescale 1ns/1ps
module pla_array
   import pla_pkg::*;
#(
   parameter int N_IN       = 16,
   parameter int N_TERM     = 48,
   parameter int N_OUT      = 8,
   parameter bit OPEN_DRAIN = 1'b0,
   localparam int TW = $clog2(N_TERM),
   localparam int IW = $clog2((N_IN > N_OUT) ? N_IN : N_OUT)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_sel,
   input  logic [TW-1:0]    cfg_term,
   input  logic [IW-1:0]    cfg_idx,
   input  logic             cfg_blow,
   output logic             cfg_rdata,
   output logic             cfg_err,
   input  logic             ce_n,
   input  logic [N_IN-1:0]  data_in,
   output logic [N_OUT-1:0] out_val,
   output logic [N_OUT-1:0] out_en
);
   if (N_IN < 2 || N_OUT < 2 || N_TERM < 2) begin : g_bad_size
      $error("pla_array: N_IN, N_OUT and N_TERM must each be at least 2");
   end

   logic [N_TERM*N_IN-1:0]  and_t_ok, and_c_ok;
   logic [N_TERM*N_OUT-1:0] or_ok;
   logic [N_OUT-1:0]        pol_ok;
   logic [N_TERM-1:0]       term_hit;
   logic [N_OUT-1:0]        result;

   pla_fuse_bank #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TW(TW), .IW(IW)) u_bank (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(pla_sel_e'(cfg_sel)),
      .cfg_term(cfg_term), .cfg_idx(cfg_idx), .cfg_blow(cfg_blow),
      .and_t_ok(and_t_ok), .and_c_ok(and_c_ok), .or_ok(or_ok), .pol_ok(pol_ok),
      .rd_intact(cfg_rdata), .cfg_err(cfg_err)
   );

   pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
      .data_in(data_in), .and_t_ok(and_t_ok), .and_c_ok(and_c_ok), .term_hit(term_hit)
   );

   pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
      .term_hit(term_hit), .or_ok(or_ok), .pol_ok(pol_ok), .result(result)
   );

   if (OPEN_DRAIN) begin : g_oc
      // pull low only where the result is 0; otherwise the wire floats high
      assign out_en  = ce_n ? '0 : ~result;
      assign out_val = ~out_en;
   end else begin : g_tri
      assign out_en  = {N_OUT{~ce_n}};
      assign out_val = ce_n ? '0 : result;
   end

   // R1
   virgin_off_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (term_hit == '0));

   // R8
   always_comb begin
      if (ce_n === 1'b1) begin
         ce_off_chk: assert (out_en == '0);
      end
   end
endmodule

// File: tb/pla_array_test.sv
`timescale 1ns/1ps
module pla_array_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we, cfg_blow, ce_n;
   logic [1:0]  cfg_sel;
   logic [5:0]  cfg_term;
   logic [3:0]  cfg_idx;
   logic [15:0] data_in;
   logic        cfg_rdata, cfg_err, rdata_oc, err_oc;
   logic [7:0]  out_val, out_en, oval_oc, oen_oc;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [15:0] mt [48];
   logic [15:0] mc [48];
   logic [7:0]  mo [48];
   logic [7:0]  mp;

   always #2 clk = ~clk;

   pla_array #(.OPEN_DRAIN(1'b0)) uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_term(cfg_term),
      .cfg_idx(cfg_idx), .cfg_blow(cfg_blow), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
      .ce_n(ce_n), .data_in(data_in), .out_val(out_val), .out_en(out_en));

   pla_array #(.OPEN_DRAIN(1'b1)) uut_oc (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_term(cfg_term),
      .cfg_idx(cfg_idx), .cfg_blow(cfg_blow), .cfg_rdata(rdata_oc), .cfg_err(err_oc),
      .ce_n(ce_n), .data_in(data_in), .out_val(oval_oc), .out_en(oen_oc));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_res(logic [15:0] v);
      logic [7:0] r = '0;
      for (int o = 0; o < 8; o++) begin
         logic s = 1'b0;
         for (int p = 0; p < 48; p++) begin
            logic hit = 1'b1;
            for (int i = 0; i < 16; i++) begin
               if (mt[p][i] && mc[p][i]) hit = 1'b0;
               else if (mt[p][i] && !v[i]) hit = 1'b0;
               else if (mc[p][i] && v[i]) hit = 1'b0;
            end
            if (hit && mo[p][o]) s = 1'b1;
         end
         r[o] = s ^ ~mp[o];
      end
      return r;
   endfunction

   function automatic logic model_link(int sel, int term, int idx);
      if (term >= 48) return 1'b0;
      if (sel < 2 && idx >= 16) return 1'b0;
      if (sel >= 2 && idx >= 8) return 1'b0;
      case (sel)
         0: return mt[term][idx];
         1: return mc[term][idx];
         2: return mo[term][idx];
         default: return mp[idx];
      endcase
   endfunction

   task automatic model_virgin();
      for (int p = 0; p < 48; p++) begin
         mt[p] = '1; mc[p] = '1; mo[p] = '1;
      end
      mp = '1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      model_virgin();
   endtask

   // R5 R6: error flag one cycle after the write, model updated on success
   task automatic do_write(int sel, int term, int idx, logic blow, string req);
      logic in_rng, cur, exp_err;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_term = 6'(term); cfg_idx = 4'(idx); cfg_blow = blow;
      in_rng = (term < 48) && ((sel < 2) ? (idx < 16) : (idx < 8));
      cur = model_link(sel, term, idx);
      exp_err = !in_rng || (!blow && !cur);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      check(req, {31'b0, cfg_err}, {31'b0, exp_err});
      check(req, {31'b0, err_oc}, {31'b0, exp_err});
      if (in_rng && blow) begin
         case (sel)
            0: mt[term][idx] = 1'b0;
            1: mc[term][idx] = 1'b0;
            2: mo[term][idx] = 1'b0;
            default: mp[idx] = 1'b0;
         endcase
      end
   endtask

   task automatic rb_check(int sel, int term, int idx, string req);
      @(negedge clk);
      cfg_sel = 2'(sel); cfg_term = 6'(term); cfg_idx = 4'(idx);
      #1;
      check(req, {31'b0, cfg_rdata}, {31'b0, model_link(sel, term, idx)});
   endtask

   task automatic rb_sweep(string req);
      for (int s = 0; s < 4; s++)
         for (int p = 0; p < ((s == 3) ? 1 : 48); p++)
            for (int i = 0; i < ((s < 2) ? 16 : 8); i++)
               rb_check(s, p, i, req);
   endtask

   // R9 R10: both output styles against the model
   task automatic out_check(logic [15:0] v, logic ce, string req);
      logic [7:0] r;
      @(negedge clk);
      data_in = v; ce_n = ce;
      #1;
      r = model_res(v);
      check({req, " R9 en"},  {24'b0, out_en},  {24'b0, ce ? 8'h00 : 8'hFF});
      check({req, " R9 val"}, {24'b0, out_val}, {24'b0, ce ? 8'h00 : r});
      check({req, " R10 en"}, {24'b0, oen_oc},  {24'b0, ce ? 8'h00 : ~r});
      check({req, " R10 val"},{24'b0, oval_oc}, {24'b0, ce ? 8'hFF : r});
   endtask

   task automatic random_program();
      for (int p = 0; p < 48; p++) begin
         int keep_o = ($urandom % 6 == 0) ? int'($urandom % 16) : -1;
         for (int i = 0; i < 16; i++) begin
            int r = $urandom % 8;
            if (i == keep_o) continue;
            if (r == 0) do_write(1, p, i, 1'b1, "R5");
            else if (r == 1) do_write(0, p, i, 1'b1, "R5");
            else begin
               do_write(0, p, i, 1'b1, "R5");
               do_write(1, p, i, 1'b1, "R5");
            end
         end
         for (int o = 0; o < 8; o++)
            if ($urandom % 3 == 0) do_write(2, p, o, 1'b1, "R3");
      end
      for (int o = 0; o < 8; o++)
         if ($urandom % 2 == 0) do_write(3, 0, o, 1'b1, "R4");
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240613));
      rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_term = '0; cfg_idx = '0;
      cfg_blow = 1'b0; ce_n = 1'b0; data_in = '0;
      do_reset();

      // R1: virgin readback and all-zero outputs
      rb_sweep("R1 R7");
      out_check(16'h0000, 1'b0, "R1");
      out_check(16'hFFFF, 1'b0, "R1");
      out_check(16'hA5C3, 1'b0, "R1");

      // R2 R3: directed pair states
      for (int i = 0; i < 16; i++) begin
         do_write(1, 0, i, 1'b1, "R2");            // term0 true-only on every input ...
         if (i != 0) do_write(0, 0, i, 1'b1, "R2"); // ... then don't care except input 0
         do_write(0, 1, i, 1'b1, "R2");            // term1 complement-only ...
         if (i != 3) do_write(1, 1, i, 1'b1, "R2"); // ... don't care except input 3
         do_write(0, 2, i, 1'b1, "R2");            // term2 all don't care
         do_write(1, 2, i, 1'b1, "R2");
         if (i != 7) begin                         // term3 don't care except an intact pair
            do_write(0, 3, i, 1'b1, "R2");
            do_write(1, 3, i, 1'b1, "R2");
         end
      end
      for (int o = 0; o < 8; o++) begin
         if (o != 0) do_write(2, 0, o, 1'b1, "R3");
         if (o != 1) do_write(2, 1, o, 1'b1, "R3");
         if (o != 2) do_write(2, 2, o, 1'b1, "R3");
         if (o != 3) do_write(2, 3, o, 1'b1, "R3");
      end
      out_check(16'h0001, 1'b0, "R2");   // expect outputs 0,1,2 high
      out_check(16'h0008, 1'b0, "R2");   // expect only output 2 high
      out_check(16'h0089, 1'b0, "R2");   // intact pair keeps output 3 low
      out_check(16'h0000, 1'b0, "R3");

      // R4: blow polarity on outputs 2 and 5
      do_write(3, 0, 2, 1'b1, "R4");
      do_write(3, 0, 5, 1'b1, "R4");
      out_check(16'h0001, 1'b0, "R4");
      out_check(16'h0008, 1'b0, "R4");

      // R5: restore attempts and a harmless blow=0 write
      do_write(2, 0, 1, 1'b0, "R5 restore");
      rb_check(2, 0, 1, "R5 stays blown");
      do_write(3, 0, 2, 1'b0, "R5 restore pol");
      rb_check(3, 0, 2, "R5 pol stays blown");
      do_write(2, 0, 0, 1'b0, "R5 intact noop");
      rb_check(2, 0, 0, "R5 still intact");
      out_check(16'h0001, 1'b0, "R5");

      // R6: out-of-range addresses
      do_write(0, 50, 0, 1'b1, "R6 term");
      do_write(2, 4, 9, 1'b1, "R6 or idx");
      do_write(3, 0, 12, 1'b1, "R6 pol idx");
      rb_check(2, 4, 1, "R6 no alias");
      rb_check(2, 50, 0, "R7 out of range");

      // R8: chip disabled
      out_check(16'h0001, 1'b1, "R8");
      out_check(16'hFFFF, 1'b1, "R8");

      rb_sweep("R7 directed");

      // random fuse maps
      for (int round = 0; round < 2; round++) begin
         do_reset();
         random_program();
         rb_sweep("R7 random");
         for (int k = 0; k < 400; k++)
            out_check(16'($urandom), ($urandom % 8 == 0), "R2 R3 R4 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule